// File: doc/BRIEF.md
# Double-to-Single Float Narrowing Unit

This unit narrows one IEEE-754 binary64 value to binary32 and places the result in the lowest 32-bit lane of a 128-bit register image. The other three lanes come through untouched from the old destination value supplied with the operation. The result is rounded under a 2-bit rounding mode. Five exception conditions are detected on every operation: invalid, denormal operand, overflow, underflow and precision.

Each exception class has a mask bit. When every raised condition is masked, the unit writes the default result. When any raised condition is unmasked, it raises a trap request and leaves the whole destination image unchanged. Operations are accepted every cycle and come out after one register stage.

Top module: `fcvt_narrow_unit`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. While reset is held and afterwards until the first result, `out_valid`, `dst_o`, `flags_o` and `trap_o` are all zero.
- R2: When no trap is raised, bits 127:32 of `dst_o` equal bits 127:32 of `dst_old_i` from the accepting cycle, and bits 31:0 hold the binary32 result.
- R3: The rounding mode field encodes 00 as nearest-even, 01 as toward minus infinity, 10 as toward plus infinity and 11 as toward zero. Every inexact finite result is rounded in that mode.
- R4: The flag and mask bit positions are: bit 0 invalid, bit 1 denormal operand, bit 2 overflow, bit 3 underflow, bit 4 precision. A mask bit of 1 masks its class.
- R5: A signalling NaN (quiet bit 51 clear) raises invalid. It yields a quiet NaN with the same sign, the quiet bit 22 set, and result bits 21:0 taken from source bits 50:29. A quiet NaN converts in the same way and raises no flag.
- R6: A source with exponent field zero and a nonzero fraction raises the denormal flag. It rounds to zero or to the smallest denormal according to the mode, with underflow and precision set.
- R7: When the magnitude exceeds the binary32 range, either before or after rounding, overflow and precision are raised. The result is infinity or the largest finite value of the source sign, as the mode directs: nearest-even gives infinity; toward zero gives the largest finite value; toward minus infinity gives infinity for negatives and the largest finite value for positives; toward plus infinity is the reverse.
- R8: A result below the binary32 normal range is shifted into denormal form and then rounded. Tininess is judged before rounding. Underflow is raised only if the result is tiny and inexact, so an exactly representable tiny value raises nothing.
- R9: Infinities and zeros convert exactly, keep their sign and raise no flags.
- R10: `trap_o` is set exactly when some flag is raised whose mask bit is 0. In that case `dst_o` equals the whole old destination and `flags_o` still reports every raised condition.
- R11: A source that is exactly representable in binary32 converts with no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| src_i | input | 64 | binary64 source value |
| dst_old_i | input | 128 | Previous destination register image |
| rmode_i | input | 2 | Rounding mode (R3 encoding) |
| mask_i | input | 5 | Exception masks (R4 positions) |
| out_valid | output | 1 | Result present |
| dst_o | output | 128 | New destination register image |
| flags_o | output | 5 | Conditions raised by this operation |
| trap_o | output | 1 | Unmasked exception present |

## Verification
The conversion is exercised with five kinds of input:
- Exact normals, which show that no stray flag is raised.
- Values one unit past an exact result and exact ties, run in all four modes. These separate the increment rule of each mode, including round-half-to-even against round-half-up.
- Values at and just beyond the top of the range. These separate overflow detected before rounding from overflow produced by the round-up carry, and the nearest-even case from the toward-zero case.
- Tiny values, both exact and inexact, together with denormal sources. These show that the denormalising shift lands on the right bit and that underflow needs inexactness.
- NaNs, infinities and zeros of both signs, repeated with selected masks cleared. These show the special encodings and that a trap keeps the old destination image whole.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    // source and result formats
    localparam int IEW   = 11;
    localparam int IFW   = 52;
    localparam int OEW   = 8;
    localparam int OFW   = 23;
    localparam int IW    = 1 + IEW + IFW;
    localparam int OW    = 1 + OEW + OFW;
    localparam int IBIAS = (1 << (IEW - 1)) - 1;
    localparam int OBIAS = (1 << (OEW - 1)) - 1;
    localparam int BDIFF = IBIAS - OBIAS;
    localparam int SIGW  = IFW + 1;           // significand with hidden bit
    localparam int KEEP  = OFW + 1;           // result significand bits
    localparam int DROP  = SIGW - KEEP;       // bits below the result lsb
    localparam int XEW   = IEW + 1;           // signed rebiased exponent
    localparam int SHW   = $clog2(SIGW) + 1;  // shift amount width
    localparam int EMAXO = (1 << OEW) - 1;    // all-ones result exponent

    // flag / mask positions
    localparam int NFLAG  = 5;
    localparam int FL_INV = 0;
    localparam int FL_DEN = 1;
    localparam int FL_OVF = 2;
    localparam int FL_UNF = 3;
    localparam int FL_PRE = 4;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic                  sign;
        logic                  is_nan;
        logic                  is_snan;
        logic                  is_inf;
        logic                  is_zero;
        logic                  is_sub;
        logic signed [XEW-1:0] exp_t;    // exponent rebiased to the result format
        logic [SIGW-1:0]       sig;
        logic [OFW-2:0]        payload;  // NaN payload bits kept in the result
    } opnd_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [IW-1:0] src,
    output opnd_t         op
);
    logic [IEW-1:0] exp_f;
    logic [IFW-1:0] frac_f;
    logic [IEW-1:0] exp_eff;
    logic           exp_one;
    logic           exp_nil;
    logic           frac_nz;

    always_comb begin
        exp_f   = src[IW-2:IFW];
        frac_f  = src[IFW-1:0];
        exp_one = &exp_f;
        exp_nil = ~|exp_f;
        frac_nz = |frac_f;
        // a subnormal source has the same scale as exponent field 1
        exp_eff = exp_nil ? IEW'(1) : exp_f;

        op.sign    = src[IW-1];
        op.is_nan  = exp_one & frac_nz;
        op.is_snan = exp_one & frac_nz & ~frac_f[IFW-1];
        op.is_inf  = exp_one & ~frac_nz;
        op.is_zero = exp_nil & ~frac_nz;
        op.is_sub  = exp_nil & frac_nz;
        op.exp_t   = $signed({1'b0, exp_eff}) - $signed(XEW'(BDIFF));
        op.sig     = {~exp_nil, frac_f};
        op.payload = frac_f[IFW-2 -: OFW-1];
    end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
(
    input  opnd_t             op,
    input  rmode_e            rm,
    output logic [OW-1:0]     res,
    output logic [NFLAG-1:0]  flg
);
    logic signed [XEW-1:0] diff;
    logic                  tiny;
    logic                  big;
    logic [SHW-1:0]        sh;
    logic [SIGW-1:0]       shifted;
    logic [SIGW-1:0]       lostmask;
    logic                  lost;
    logic [KEEP-1:0]       kept;
    logic                  grd;
    logic                  stk;
    logic                  inexact;
    logic                  inc;
    logic [OEW-1:0]        expf;
    logic [OW-2:0]         sum;
    logic                  ovf;
    logic                  to_inf;

    always_comb begin
        diff = $signed(XEW'(1)) - op.exp_t;
        tiny = op.exp_t < $signed(XEW'(1));
        big  = op.exp_t >= $signed(XEW'(EMAXO));

        // denormalising shift, saturated at the significand width
        if (!tiny)
            sh = '0;
        else if (diff > $signed(XEW'(SIGW)))
            sh = SHW'(SIGW);
        else
            sh = diff[SHW-1:0];

        shifted  = op.sig >> sh;
        lostmask = (sh >= SHW'(SIGW)) ? '1 : ((SIGW'(1) << sh) - SIGW'(1));
        lost     = |(op.sig & lostmask);

        kept    = shifted[SIGW-1 -: KEEP];
        grd     = shifted[DROP-1];
        stk     = (|shifted[DROP-2:0]) | lost;
        inexact = grd | stk;

        unique case (rm)
            RM_NEAR: inc = grd & (stk | kept[0]);
            RM_DOWN: inc = op.sign & inexact;
            RM_UP:   inc = ~op.sign & inexact;
            RM_ZERO: inc = 1'b0;
            default: inc = 1'b0;
        endcase

        expf = tiny ? '0 : op.exp_t[OEW-1:0];
        // carry out of the fraction lifts the exponent (also denormal to normal)
        sum  = {expf, kept[KEEP-2:0]} + (OW-1)'(inc);
        ovf  = big | (&sum[OW-2:OFW]);

        unique case (rm)
            RM_NEAR: to_inf = 1'b1;
            RM_DOWN: to_inf = op.sign;
            RM_UP:   to_inf = ~op.sign;
            RM_ZERO: to_inf = 1'b0;
            default: to_inf = 1'b0;
        endcase

        flg = '0;
        if (op.is_nan) begin
            res         = {op.sign, {OEW{1'b1}}, 1'b1, op.payload};
            flg[FL_INV] = op.is_snan;
        end else if (op.is_inf) begin
            res = {op.sign, {OEW{1'b1}}, {OFW{1'b0}}};
        end else if (op.is_zero) begin
            res = {op.sign, {(OW-1){1'b0}}};
        end else begin
            flg[FL_DEN] = op.is_sub;
            if (ovf) begin
                res = to_inf ? {op.sign, {OEW{1'b1}}, {OFW{1'b0}}}
                             : {op.sign, {(OEW-1){1'b1}}, 1'b0, {OFW{1'b1}}};
                flg[FL_OVF] = 1'b1;
                flg[FL_PRE] = 1'b1;
            end else begin
                res         = {op.sign, sum};
                flg[FL_PRE] = inexact;
                flg[FL_UNF] = tiny & inexact;
            end
        end
    end
endmodule

// File: rtl/fcvt_narrow_unit.sv
module fcvt_narrow_unit
    import fcvt_pkg::*;
#(
    parameter int DST_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IW-1:0]     src_i,
    input  logic [DST_W-1:0]  dst_old_i,
    input  logic [1:0]        rmode_i,
    input  logic [NFLAG-1:0]  mask_i,
    output logic              out_valid,
    output logic [DST_W-1:0]  dst_o,
    output logic [NFLAG-1:0]  flags_o,
    output logic              trap_o
);
    localparam int UPW = DST_W - OW;  // preserved upper lanes

    typedef struct packed {
        logic             valid;
        logic [DST_W-1:0] dst;
        logic [NFLAG-1:0] flags;
        logic             trap;
    } stage_t;

    opnd_t            op;
    logic [OW-1:0]    res;
    logic [NFLAG-1:0] flg;
    stage_t           st_d;
    stage_t           st_q;

    fcvt_unpack u_unpack (
        .src (src_i),
        .op  (op)
    );

    fcvt_round u_round (
        .op  (op),
        .rm  (rmode_e'(rmode_i)),
        .res (res),
        .flg (flg)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.flags = flg;
            st_d.trap  = |(flg & ~mask_i);
            st_d.dst   = st_d.trap ? dst_old_i : {dst_old_i[DST_W-1:OW], res};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign dst_o     = st_q.dst;
    assign flags_o   = st_q.flags;
    assign trap_o    = st_q.trap;

    // R1: one-cycle latency
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R2: upper lanes carried through
    assert_upper_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> dst_o[DST_W-1:OW] == $past(dst_old_i[DST_W-1:OW]));

    // R10: trap follows unmasked flags
    assert_trap_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> trap_o == |(flags_o & ~$past(mask_i)));

    // R10: a trap leaves the whole image unchanged
    assert_trap_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && trap_o) |-> dst_o == $past(dst_old_i));

    // R7: overflow always comes with precision
    assert_ovf_pre_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_o[FL_OVF]) |-> flags_o[FL_PRE]);

    // R8: underflow needs inexactness
    assert_unf_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_o[FL_UNF]) |-> flags_o[FL_PRE]);

    // R5: any NaN written out is quiet
    assert_nan_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !trap_o && (&dst_o[OW-2:OFW]) && (|dst_o[OFW-1:0]))
            |-> dst_o[OFW-1]);
endmodule

// File: tb/tb_fcvt_narrow_unit.sv
module tb_fcvt_narrow_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  src_i = '0;
    logic [127:0] dst_old_i = '0;
    logic [1:0]   rmode_i = '0;
    logic [4:0]   mask_i = '0;
    logic         out_valid;
    logic [127:0] dst_o;
    logic [4:0]   flags_o;
    logic         trap_o;

    int checks = 0;
    int failures = 0;
    int nvec = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [127:0] dst;
        logic [4:0]   flg;
        logic         trap;
        string        tag;
    } item_t;
    item_t sb[$];

    // modes and masks (R3, R4)
    localparam logic [1:0] NE = 2'b00, DN = 2'b01, UP = 2'b10, TZ = 2'b11;
    localparam logic [4:0] MALL = 5'h1F;

    fcvt_narrow_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_i(src_i),
        .dst_old_i(dst_old_i), .rmode_i(rmode_i), .mask_i(mask_i),
        .out_valid(out_valid), .dst_o(dst_o), .flags_o(flags_o), .trap_o(trap_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: apply one operation and push its expectation
    task automatic send(input logic [63:0] s, input logic [1:0] rm, input logic [4:0] msk,
                        input logic [31:0] res, input logic [4:0] flg, input string tag);
        item_t it;
        logic [127:0] old;
        @(negedge clk);
        nvec++;
        old = {32'h5A5A0000 + nvec, 32'hC3C30000 ^ nvec, 32'h0F0F0000 | nvec, 32'hFFFF0000 | nvec};
        in_valid  = 1'b1;
        src_i     = s;
        rmode_i   = rm;
        mask_i    = msk;
        dst_old_i = old;
        it.flg  = flg;
        it.trap = |(flg & ~msk);                       // R10
        it.dst  = it.trap ? old : {old[127:32], res};  // R2, R10
        it.tag  = tag;
        sb.push_back(it);
    endtask

    // monitor: compare each result as it appears
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected result", 128'(out_valid), 128'(0));
            end else begin
                item_t it;
                it = sb.pop_front();
                check(dst_o === it.dst, {it.tag, " dst"}, dst_o, it.dst);
                check(flags_o === it.flg, {it.tag, " flags"}, 128'(flags_o), 128'(it.flg));
                check(trap_o === it.trap, {it.tag, " trap"}, 128'(trap_o), 128'(it.trap));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && dst_o === '0 && flags_o === '0 && trap_o === 1'b0,
              "R1 reset state", {dst_o[123:0], out_valid, trap_o, flags_o[1:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 idle after reset", 128'(out_valid), 128'(0));

        // R11 exact values
        send(64'h3FF0000000000000, NE, MALL, 32'h3F800000, 5'h00, "R11 one");
        send(64'hC004000000000000, DN, MALL, 32'hC0200000, 5'h00, "R11 minus 2.5");
        // R3 one ulp past an exact value, all modes and both signs
        send(64'h3FF0000000000001, NE, MALL, 32'h3F800000, 5'h10, "R3 near");
        send(64'h3FF0000000000001, DN, MALL, 32'h3F800000, 5'h10, "R3 down");
        send(64'h3FF0000000000001, UP, MALL, 32'h3F800001, 5'h10, "R3 up");
        send(64'h3FF0000000000001, TZ, MALL, 32'h3F800000, 5'h10, "R3 zero");
        send(64'hBFF0000000000001, DN, MALL, 32'hBF800001, 5'h10, "R3 down neg");
        send(64'hBFF0000000000001, UP, MALL, 32'hBF800000, 5'h10, "R3 up neg");
        // R3 ties to even
        send(64'h3FF0000010000000, NE, MALL, 32'h3F800000, 5'h10, "R3 tie even stays");
        send(64'h3FF0000030000000, NE, MALL, 32'h3F800002, 5'h10, "R3 tie odd rounds up");
        // R5 NaNs
        send(64'h7FF0000000000001, NE, MALL, 32'h7FC00000, 5'h01, "R5 snan");
        send(64'h7FF4000000000000, NE, MALL, 32'h7FE00000, 5'h01, "R5 snan payload");
        send(64'hFFF8000000000000, TZ, MALL, 32'hFFC00000, 5'h00, "R5 qnan");
        // R9 specials
        send(64'h7FF0000000000000, NE, MALL, 32'h7F800000, 5'h00, "R9 +inf");
        send(64'hFFF0000000000000, UP, MALL, 32'hFF800000, 5'h00, "R9 -inf");
        send(64'h8000000000000000, DN, MALL, 32'h80000000, 5'h00, "R9 -zero");
        send(64'h0000000000000000, UP, 5'h00, 32'h00000000, 5'h00, "R9 +zero unmasked");
        // R7 overflow before rounding
        send(64'h47F0000000000000, NE, MALL, 32'h7F800000, 5'h14, "R7 pos near");
        send(64'h47F0000000000000, DN, MALL, 32'h7F7FFFFF, 5'h14, "R7 pos down");
        send(64'h47F0000000000000, UP, MALL, 32'h7F800000, 5'h14, "R7 pos up");
        send(64'h47F0000000000000, TZ, MALL, 32'h7F7FFFFF, 5'h14, "R7 pos zero");
        send(64'hC7F0000000000000, NE, MALL, 32'hFF800000, 5'h14, "R7 neg near");
        send(64'hC7F0000000000000, DN, MALL, 32'hFF800000, 5'h14, "R7 neg down");
        send(64'hC7F0000000000000, UP, MALL, 32'hFF7FFFFF, 5'h14, "R7 neg up");
        // R7 overflow caused by rounding carry vs truncation
        send(64'h47EFFFFFF0000000, NE, MALL, 32'h7F800000, 5'h14, "R7 round carry");
        send(64'h47EFFFFFF0000000, TZ, MALL, 32'h7F7FFFFF, 5'h10, "R7 truncated max");
        // R6 denormal sources
        send(64'h0000000000000001, NE, MALL, 32'h00000000, 5'h1A, "R6 near");
        send(64'h0000000000000001, UP, MALL, 32'h00000001, 5'h1A, "R6 up");
        send(64'h8000000000000001, DN, MALL, 32'h80000001, 5'h1A, "R6 down neg");
        // R8 tiny results
        send(64'h36A0000000000000, NE, 5'h00, 32'h00000001, 5'h00, "R8 exact tiny");
        send(64'h36A8000000000000, NE, MALL, 32'h00000002, 5'h18, "R8 tiny tie up");
        send(64'h36A8000000000000, TZ, MALL, 32'h00000001, 5'h18, "R8 tiny truncated");
        // R10 traps, R4 mask positions
        send(64'h3FF0000000000001, NE, 5'h0F, 32'h3F800000, 5'h10, "R10 precision unmasked");
        send(64'h7FF0000000000001, NE, 5'h1E, 32'h7FC00000, 5'h01, "R10 invalid unmasked");
        send(64'h47F0000000000000, NE, 5'h1B, 32'h7F800000, 5'h14, "R4 overflow unmasked");
        send(64'h47F0000000000000, NE, 5'h0B, 32'h7F800000, 5'h14, "R4 unrelated bits clear");
        send(64'h0000000000000001, NE, 5'h1D, 32'h00000000, 5'h1A, "R4 denormal unmasked");
        send(64'h3FF0000000000000, NE, 5'h00, 32'h3F800000, 5'h00, "R10 exact no trap");

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 valid drops", 128'(out_valid), 128'(0));
        check(sb.size() == 0, "R1 all results seen", 128'(sb.size()), 128'(0));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule